// File: doc/BRIEF.md
# Synthesizer Reference Divider and Sample-Clock Selector

This block holds the digital dividers of an integer-N frequency synthesizer. A programmable down-counter divides the reference clock by an 8-bit ratio R, so that a reference of R × 200 kHz gives one comparison pulse every 5 µs. Typical pairings are 9.6 MHz with R = 48, 13.0 MHz with R = 65, 14.4 MHz with R = 72, 19.2 MHz with R = 96 and 26.0 MHz with R = 130. Configuration logic outside the block should load R = 96 and select the reference clock after reset. On the local-oscillator clock, fixed counters model the synthesizer ratios. The RF LO is 8064 times the comparison rate, and the IF LO is 168 times the comparison rate, which is the RF LO divided by 48.

The block also drives the ADC sample clock. It is either the reference clock passed through unchanged or the RF LO divided by 96, which is 16.8 MHz nominal. A changeover between the two sources goes through a break-before-make handoff, and each clock domain has its own synchronisers. A standby request stops the dividers and the sample clock, but only while the reference source is selected. A low divider-run control holds every divider in reset and keeps the phase-detector pulses inactive. The reference passthrough is not affected by it.

Top module: `synth_div_top`

## Requirements
- R1: With a stable R of 2 or more, `cmp_pulse_o` is high for exactly one reference cycle in every R reference cycles (R = 48, 65, 72, 96, 130, 255 and 2 included).
- R2: An R of 0 or 1 divides by one: `cmp_pulse_o` is high in every reference cycle.
- R3: A change of R does not cut the count in progress. The next pulse comes at the old interval, and every later interval uses the new R.
- R4: While running, `fb_pulse_o` is a one-LO-cycle pulse every 8064 LO cycles, and `if_clk_o` is a square wave with a period of 48 LO cycles.
- R5: With `clk_sel_i` = 1 and no standby, `smp_clk_o` equals `ref_clk_i` and `ref_sel_o` is 1.
- R6: With `clk_sel_i` = 0, `smp_clk_o` is the LO clock divided by 96: its period is 96 LO cycles and it is high for 48 of them. `ref_sel_o` is 0.
- R7: A change of source never enables both sources together. The old source is gated off in its low phase before the new one is gated on, so `smp_clk_o` never has a high or low phase shorter than the shorter half period of the two sources.
- R8: With `standby_i` = 1 and `clk_sel_i` = 1, the following all stop and `ref_sel_o` reads 0: the comparison pulses, the feedback pulses, `if_clk_o` and `smp_clk_o`. Operation resumes when standby is removed.
- R9: With `clk_sel_i` = 0, `standby_i` has no effect: comparison pulses and the divided-LO sample clock continue.
- R10: While `div_run_i` = 0, `cmp_pulse_o`, `fb_pulse_o` and `if_clk_o` stay low, and the reference passthrough on `smp_clk_o` continues. After release, the pulses resume at their programmed intervals.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock |
| lo_clk_i | input | 1 | RF local-oscillator rate clock |
| ratio_i | input | 8 | Reference divide ratio R (0 and 1 mean divide by one) |
| clk_sel_i | input | 1 | 1: sample clock from the reference, 0: from the LO divided by 96 |
| standby_i | input | 1 | Standby request, honoured only while `clk_sel_i` = 1 |
| div_run_i | input | 1 | Active-low divider hold: 0 holds all dividers in reset |
| cmp_pulse_o | output | 1 | Comparison pulse, reference domain |
| fb_pulse_o | output | 1 | Feedback pulse (LO / 8064), LO domain |
| if_clk_o | output | 1 | IF LO model (LO / 48) |
| smp_clk_o | output | 1 | ADC sample clock |
| ref_sel_o | output | 1 | 1 while the reference source drives the sample clock |

## Verification
A corrupt down-counter value or reload value shows up as a wrong comparison-pulse spacing. The interval that follows the fault already has the wrong length, so the scoreboard catches it at the next pulse, within R reference cycles. A fault in the handoff enables shows at the sample-clock pin. An overlap of the two sources gives a high or low phase shorter than 5 ns. A stuck enable leaves `ref_sel_o` or the clock period wrong a few microseconds after the select changes. Faults in the LO counters show at the next feedback pulse or the next IF edge.

// File: rtl/synth_div_pkg.sv
`timescale 1ns/1ps
package synth_div_pkg;
  localparam int unsigned RATIO_W  = 8;
  localparam int unsigned SMP_DIV  = 96;
  localparam int unsigned IF_DIV   = 48;
  localparam int unsigned FB_DIV   = 8064;
  localparam int unsigned SYNC_LEN = 2;
endpackage

// File: rtl/synth_sync.sv
`timescale 1ns/1ps
module synth_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned LEN   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(LEN); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(LEN); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[LEN-1];
endmodule

// File: rtl/synth_pulse_div.sv
`timescale 1ns/1ps
module synth_pulse_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] load_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  // load_i = N-1 gives one pulse every N cycles; reload sampled at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= load_i;
      pulse_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= load_i;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/synth_half_div.sv
`timescale 1ns/1ps
module synth_half_div #(
  parameter int unsigned DIV = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = div_q;
endmodule

// File: rtl/synth_clk_handoff.sv
`timescale 1ns/1ps
module synth_clk_handoff #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic alt_clk_i,
  input  logic alt_div_i,
  input  logic want_ref_i,
  input  logic want_alt_i,
  output logic ref_en_o,
  output logic alt_en_o,
  output logic clk_o
);
  logic ref_go, alt_go;
  logic ref_en_q, alt_en_q;

  synth_sync #(.WIDTH(1), .LEN(SYNC_LEN)) u_ref_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_ref_i & ~alt_en_q),
    .q_o   (ref_go)
  );

  synth_sync #(.WIDTH(1), .LEN(SYNC_LEN)) u_alt_sync (
    .clk_i (alt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_alt_i & ~ref_en_q),
    .q_o   (alt_go)
  );

  // enable changes only while its own source is low
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_en_q <= 1'b0;
    else         ref_en_q <= ref_go;
  end

  always_ff @(negedge alt_clk_i or negedge rst_ni) begin
    if (!rst_ni)         alt_en_q <= 1'b0;
    else if (!alt_div_i) alt_en_q <= alt_go;
  end

  assign ref_en_o = ref_en_q;
  assign alt_en_o = alt_en_q;
  assign clk_o    = (ref_clk_i & ref_en_q) | (alt_div_i & alt_en_q);
endmodule

// File: rtl/synth_div_top.sv
`timescale 1ns/1ps
module synth_div_top
  import synth_div_pkg::*;
#(
  parameter int unsigned R_W    = RATIO_W,
  parameter int unsigned S_DIV  = SMP_DIV,
  parameter int unsigned I_DIV  = IF_DIV,
  parameter int unsigned F_DIV  = FB_DIV,
  parameter int unsigned S_LEN  = SYNC_LEN
) (
  input  logic           rst_ni,
  input  logic           ref_clk_i,
  input  logic           lo_clk_i,
  input  logic [R_W-1:0] ratio_i,
  input  logic           clk_sel_i,
  input  logic           standby_i,
  input  logic           div_run_i,
  output logic           cmp_pulse_o,
  output logic           fb_pulse_o,
  output logic           if_clk_o,
  output logic           smp_clk_o,
  output logic           ref_sel_o
);
  localparam int unsigned FB_W = $clog2(F_DIV);
  localparam int unsigned NCFG = 3;

  logic [NCFG-1:0] cfg_ref_s, cfg_lo_s;
  logic            run_ref, run_lo;
  logic [R_W-1:0]  ref_load;
  logic [1:0]      half_clk;
  logic            ref_en, alt_en;

  // cfg bits: [2] run, [1] standby, [0] select-reference
  synth_sync #(.WIDTH(NCFG), .LEN(S_LEN)) u_cfg_ref (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({div_run_i, standby_i, clk_sel_i}),
    .q_o   (cfg_ref_s)
  );

  synth_sync #(.WIDTH(NCFG), .LEN(S_LEN)) u_cfg_lo (
    .clk_i (lo_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({div_run_i, standby_i, clk_sel_i}),
    .q_o   (cfg_lo_s)
  );

  // standby counts only when the reference source is selected
  assign run_ref = cfg_ref_s[2] & ~(cfg_ref_s[1] & cfg_ref_s[0]);
  assign run_lo  = cfg_lo_s[2]  & ~(cfg_lo_s[1]  & cfg_lo_s[0]);

  assign ref_load = (ratio_i <= R_W'(1)) ? '0 : ratio_i - 1'b1;

  synth_pulse_div #(.W(R_W)) u_ref_div (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_ref),
    .load_i (ref_load),
    .pulse_o(cmp_pulse_o)
  );

  synth_pulse_div #(.W(FB_W)) u_fb_div (
    .clk_i  (lo_clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_lo),
    .load_i (FB_W'(F_DIV - 1)),
    .pulse_o(fb_pulse_o)
  );

  // [0]: sample-clock LO divider, [1]: IF LO divider
  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int unsigned D = (g == 0) ? S_DIV : I_DIV;
    synth_half_div #(.DIV(D)) u_div (
      .clk_i (lo_clk_i),
      .rst_ni(rst_ni),
      .run_i (run_lo),
      .clk_o (half_clk[g])
    );
  end

  assign if_clk_o = half_clk[1];

  synth_clk_handoff #(.SYNC_LEN(S_LEN)) u_handoff (
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .alt_clk_i (lo_clk_i),
    .alt_div_i (half_clk[0]),
    .want_ref_i(clk_sel_i & ~standby_i),
    .want_alt_i(~clk_sel_i),
    .ref_en_o  (ref_en),
    .alt_en_o  (alt_en),
    .clk_o     (smp_clk_o)
  );

  assign ref_sel_o = ref_en;
endmodule

// File: rtl/synth_div_chk.sv
`timescale 1ns/1ps
module synth_div_chk #(
  parameter int unsigned R_W = 8
) (
  input logic           rst_ni,
  input logic           ref_clk_i,
  input logic           lo_clk_i,
  input logic [R_W-1:0] ratio_i,
  input logic           run_ref_i,
  input logic           run_lo_i,
  input logic           cmp_pulse_i,
  input logic           fb_pulse_i,
  input logic           ref_en_i,
  input logic           alt_en_i
);
  p_excl_ref_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !(ref_en_i && alt_en_i));

  p_excl_lo_r7: assert property (@(posedge lo_clk_i) disable iff (!rst_ni)
    !(ref_en_i && alt_en_i));

  p_alt_after_ref_r7: assert property (@(posedge lo_clk_i) disable iff (!rst_ni)
    $rose(alt_en_i) |-> !ref_en_i);

  p_ref_after_alt_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(ref_en_i) |-> !alt_en_i);

  p_hold_cmp_r10: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !run_ref_i |=> !cmp_pulse_i);

  p_hold_fb_r10: assert property (@(posedge lo_clk_i) disable iff (!rst_ni)
    !run_lo_i |=> !fb_pulse_i);

  p_cmp_single_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (cmp_pulse_i && ratio_i >= R_W'(2) && $stable(ratio_i)) |=> !cmp_pulse_i);

  p_fb_single_r4: assert property (@(posedge lo_clk_i) disable iff (!rst_ni)
    fb_pulse_i |=> !fb_pulse_i);
endmodule

bind synth_div_top synth_div_chk #(.R_W(R_W)) u_chk (
  .rst_ni     (rst_ni),
  .ref_clk_i  (ref_clk_i),
  .lo_clk_i   (lo_clk_i),
  .ratio_i    (ratio_i),
  .run_ref_i  (run_ref),
  .run_lo_i   (run_lo),
  .cmp_pulse_i(cmp_pulse_o),
  .fb_pulse_i (fb_pulse_o),
  .ref_en_i   (ref_en),
  .alt_en_i   (alt_en)
);

// File: tb/sim_synth_div_top.sv
`timescale 1ns/1ps
module sim_synth_div_top;
  logic       ref_clk = 1'b0;
  logic       lo_clk  = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] ratio   = 8'd96;
  logic       sel     = 1'b1;
  logic       stby    = 1'b0;
  logic       run     = 1'b1;
  logic       cmp_pulse, fb_pulse, if_clk, smp_clk, ref_sel;

  always #5 ref_clk = ~ref_clk;
  always #1 lo_clk  = ~lo_clk;

  synth_div_top u0 (
    .rst_ni     (rst_n),
    .ref_clk_i  (ref_clk),
    .lo_clk_i   (lo_clk),
    .ratio_i    (ratio),
    .clk_sel_i  (sel),
    .standby_i  (stby),
    .div_run_i  (run),
    .cmp_pulse_o(cmp_pulse),
    .fb_pulse_o (fb_pulse),
    .if_clk_o   (if_clk),
    .smp_clk_o  (smp_clk),
    .ref_sel_o  (ref_sel)
  );

  int total = 0;
  int bad   = 0;

  task automatic check_eq(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_min(string req, realtime act, realtime lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s actual=%0t expected>=%0t", req, act, lim);
    end
  endtask

  // scoreboard: expected comparison intervals
  int     exp_q[$];
  string  tag_q[$];
  longint cyc = 0, last_p = 0;
  int     seen = 0;
  int     e_v;
  string  t_v;

  always @(negedge ref_clk) begin
    cyc++;
    if (cmp_pulse) begin
      if (exp_q.size() > 0) begin
        e_v = exp_q.pop_front();
        t_v = tag_q.pop_front();
        check_eq(t_v, cyc - last_p, e_v);
      end
      last_p = cyc;
      seen++;
    end
  end

  // LO-domain monitors
  longint lcyc = 0, fb_last = 0, if_last = 0;
  longint fb_iv = 0, if_iv = 0;
  int     fb_cnt = 0, if_cnt = 0;
  logic   if_prev = 1'b0;

  always @(negedge lo_clk) begin
    lcyc++;
    if (fb_pulse) begin
      fb_iv = lcyc - fb_last;
      fb_last = lcyc;
      fb_cnt++;
    end
    if (if_clk && !if_prev) begin
      if_iv = lcyc - if_last;
      if_last = lcyc;
      if_cnt++;
    end
    if_prev = if_clk;
  end

  // sample-clock edge monitor
  realtime s_rise = 0, s_fall = 0, s_per = 0, s_hi = 0;
  realtime min_w = 1.0e9;
  int      s_rises = 0;

  always @(posedge smp_clk) begin
    s_per = $realtime - s_rise;
    if ($realtime - s_fall < min_w) min_w = $realtime - s_fall;
    s_rise = $realtime;
    s_rises++;
  end

  always @(negedge smp_clk) begin
    s_hi = $realtime - s_rise;
    if (s_hi < min_w) min_w = s_hi;
    s_fall = $realtime;
  end

  int wd = 0;
  always @(posedge ref_clk) begin
    wd++;
    if (wd == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_pulses(int k);
    int s0 = seen;
    wait (seen >= s0 + k);
  endtask

  task automatic run_ratio(int r, int n, string tag);
    ratio = 8'(r);
    wait_pulses(3);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((r <= 1) ? 1 : r);
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  task automatic follow_ref(string req, int n);
    int mism = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge ref_clk); #2;
      if (smp_clk !== 1'b1) mism++;
      @(negedge ref_clk); #2;
      if (smp_clk !== 1'b0) mism++;
    end
    check_eq(req, mism, 0);
  endtask

  task automatic lo_period(string req);
    int r0 = s_rises;
    wait (s_rises >= r0 + 3);
    check_eq(req, longint'(s_per), 192);
    check_eq(req, longint'(s_hi), 96);
  endtask

  int c_seen, c_fb, c_if, c_smp;

  initial begin
    repeat (3) @(negedge ref_clk);
    // R11: reset state
    check_eq("R11 cmp", cmp_pulse, 0);
    check_eq("R11 fb", fb_pulse, 0);
    check_eq("R11 if", if_clk, 0);
    check_eq("R11 smp", smp_clk, 0);
    check_eq("R11 sel", ref_sel, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge ref_clk);
    check_eq("R5 sel", ref_sel, 1);
    follow_ref("R5 follow", 8);

    run_ratio(96, 3, "R1 r96");
    run_ratio(48, 3, "R1 r48");
    run_ratio(65, 3, "R1 r65");
    run_ratio(130, 2, "R1 r130");
    run_ratio(255, 2, "R1 r255");
    run_ratio(2, 4, "R1 r2");
    run_ratio(1, 4, "R2 r1");
    run_ratio(0, 4, "R2 r0");
    run_ratio(96, 2, "R1 back96");

    // R3: change mid-count
    wait_pulses(1);
    repeat (10) @(negedge ref_clk);
    ratio = 8'd48;
    exp_q.push_back(96); tag_q.push_back("R3 old");
    exp_q.push_back(48); tag_q.push_back("R3 new");
    exp_q.push_back(48); tag_q.push_back("R3 new");
    wait (exp_q.size() == 0);
    run_ratio(96, 1, "R1 r96b");

    // R4: fixed LO ratios
    c_fb = fb_cnt;
    wait (fb_cnt >= c_fb + 2);
    check_eq("R4 fb interval", fb_iv, 8064);
    c_if = if_cnt;
    wait (if_cnt >= c_if + 2);
    check_eq("R4 if period", if_iv, 48);

    // R6/R7: switch to divided LO
    min_w = 1.0e9;
    sel = 1'b0;
    #2000;
    check_eq("R6 sel", ref_sel, 0);
    check_min("R7 to lo", min_w, 4.9);
    lo_period("R6 period");

    // R9: standby ignored with LO source
    stby = 1'b1;
    run_ratio(96, 2, "R9 cmp");
    lo_period("R9 period");
    check_eq("R9 sel", ref_sel, 0);
    stby = 1'b0;

    // R7: back to reference
    min_w = 1.0e9;
    sel = 1'b1;
    #2000;
    check_min("R7 to ref", min_w, 4.9);
    check_eq("R5 sel back", ref_sel, 1);
    follow_ref("R5 follow back", 8);

    // R8: standby with reference source
    stby = 1'b1;
    repeat (20) @(negedge ref_clk);
    c_seen = seen; c_fb = fb_cnt; c_if = if_cnt; c_smp = s_rises;
    repeat (2000) @(negedge ref_clk);
    check_eq("R8 cmp", seen - c_seen, 0);
    check_eq("R8 fb", fb_cnt - c_fb, 0);
    check_eq("R8 if", if_cnt - c_if, 0);
    check_eq("R8 smp", s_rises - c_smp, 0);
    check_eq("R8 sel", ref_sel, 0);
    stby = 1'b0;
    run_ratio(96, 2, "R8 resume");

    // R10: divider hold
    run = 1'b0;
    repeat (20) @(negedge ref_clk);
    c_seen = seen; c_fb = fb_cnt; c_if = if_cnt;
    repeat (2000) @(negedge ref_clk);
    check_eq("R10 cmp", seen - c_seen, 0);
    check_eq("R10 fb", fb_cnt - c_fb, 0);
    check_eq("R10 if", if_cnt - c_if, 0);
    follow_ref("R10 passthrough", 4);
    run = 1'b1;
    run_ratio(72, 2, "R10 release");
    c_fb = fb_cnt;
    wait (fb_cnt >= c_fb + 2);
    check_eq("R10 fb release", fb_iv, 8064);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule